// File: doc/BRIEF.md
# Programmable Prescaled Interval Timer

This block is a memory-mapped timer for a chip's peripheral space. A 28-bit counter counts upward at the input clock rate divided by a programmable prescale value. The counter returns to zero when it reaches a programmed end value or when it runs past its 28-bit limit. Each such wrap raises a sticky pending flag. When its enable is set, the flag drives a level interrupt. Software clears the flag by writing a one to it.

In periodic mode the counter keeps running after a wrap, so it produces a steady stream of interrupts. In one-shot mode it halts at zero after the first wrap and waits until software writes the control register again. The count register can be written at any time to preset the counter. Clearing the enable bit freezes the count.

Top module: `interval_timer`

## Requirements
- R1: After a synchronous active-low reset, all four registers read zero and `irq` is low.
- R2: The counter changes only on a prescaler tick, only while control bit 28 (enable) is set and the counter is not halted, and it grows by exactly one per tick; with enable clear, the count holds.
- R3: On a tick where count+1 equals a nonzero end value, the count becomes 0 and pending is set; an end value of 0 never matches.
- R4: On a tick at count 0x0FFFFFFF, the count becomes 0 and pending is set, whatever the end value.
- R5: With control bit 24 at 0 (one-shot), the counter halts at 0 after a wrap; a control write with bit 28 set restarts it.
- R6: With control bit 24 at 1 (periodic), counting continues from 0 after a wrap.
- R7: Control bits [15:0] hold a divisor d; ticks come every max(d,1) clocks, and the first one comes on the max(d,1)-th clock edge after the control write.
- R8: Interrupt register bit 16 is pending and bit 20 is interrupt enable; `irq` is high exactly when both are set; pending stays set until it is cleared.
- R9: Writing the interrupt register with bit 16 at 1 clears pending, and with bit 16 at 0 it leaves pending alone; a wrap in the same cycle as a clear leaves pending set.
- R10: A write to the count register loads bits [27:0] on that edge and wins over a tick in the same cycle.
- R11: Word address 0 is the end value, 1 the count, 2 control and 3 interrupt. The end and count registers read in bits [27:0]. Control reads only bits 28, 24 and [15:0]. The interrupt register reads only bits 20 and 16. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Word address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following:
- the step of one per tick and the hold between ticks;
- the return to zero after a wrap;
- that a halted one-shot counter stays halted;
- the minimum gap between ticks when the divisor is above one;
- that pending behaves as a sticky flag, and that a wrap wins over a clear.

Only the bench's scenarios can show the rest. These are the exact counts after an arithmetic sweep of divisors, end values and wait lengths. They also include the restart of a halted one-shot counter, the preset priority, the natural 28-bit overflow and the read masks of each register.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the interval timer.
// Assumes a 32-bit register bus addressed by word index.
package tmr_pkg;
    localparam int DATA_W       = 32;
    localparam int CTL_EN_BIT   = 28;
    localparam int CTL_MODE_BIT = 24;
    localparam int IRQ_PEND_BIT = 16;
    localparam int IRQ_EN_BIT   = 20;

    typedef enum logic [1:0] {
        REG_END = 2'd0,
        REG_CNT = 2'd1,
        REG_CTL = 2'd2,
        REG_IRQ = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_ONESHOT  = 1'b0,
        MODE_PERIODIC = 1'b1
    } run_mode_e;
endpackage

// File: rtl/tmr_regs.sv
// Register file: holds the end value, control fields and interrupt enable.
// It also produces one-cycle write strobes for the count and interrupt registers.
// Assumes single-cycle writes; reads are handled at the top.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 28,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  end_val,
    output logic              ctl_en,
    output run_mode_e         ctl_mode,
    output logic [DIV_W-1:0]  ctl_div,
    output logic              irq_en,
    output logic              wr_cnt,
    output logic              wr_ctl,
    output logic              wr_irq
);
    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    // Decode write strobes per register.
    always_comb begin
        wr_cnt = bus_we && (reg_sel_e'(bus_addr) == REG_CNT);
        wr_ctl = bus_we && (reg_sel_e'(bus_addr) == REG_CTL);
        wr_irq = bus_we && (reg_sel_e'(bus_addr) == REG_IRQ);
    end

    // Store the programmable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_val  <= '0;
            ctl_en   <= 1'b0;
            ctl_mode <= MODE_ONESHOT;
            ctl_div  <= '0;
            irq_en   <= 1'b0;
        end else begin
            if (bus_we && reg_sel_e'(bus_addr) == REG_END)
                end_val <= bus_wdata[CNT_W-1:0];
            if (wr_ctl) begin
                ctl_en   <= bus_wdata[CTL_EN_BIT];
                ctl_mode <= run_mode_e'(bus_wdata[CTL_MODE_BIT]);
                ctl_div  <= bus_wdata[DIV_W-1:0];
            end
            if (wr_irq)
                irq_en <= bus_wdata[IRQ_EN_BIT];
        end
    end
endmodule

// File: rtl/tmr_prescale.sv
// Prescaler: pulses tick once every max(div,1) clocks while run is high.
// A restart (control write) or a stop sends the phase back to zero.
module tmr_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] phase;

    // Tick when the phase reaches the last step of the divisor.
    always_comb begin
        tick = run && ((div <= ONE) || (phase == div - ONE));
    end

    // Advance the phase; clear on tick, stop or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (!run || restart || tick)
            phase <= '0;
        else
            phase <= phase + ONE;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > ONE && !restart) |=> !tick); // R7
endmodule

// File: rtl/tmr_counter.sv
// Counter core: steps on ticks, wraps at the end value or the all-ones count,
// and holds the one-shot halt flag. A preset write beats a tick.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  run_mode_e        mode,
    input  logic             wr_ctl,
    input  logic             ctl_wr_en,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] end_val,
    output logic [CNT_W-1:0] cnt,
    output logic             stopped,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_inc;

    // Find the next value and whether this tick wraps.
    always_comb begin
        cnt_inc = cnt + CNT_ONE;
        wrap    = tick && ((cnt == CNT_MAX) ||
                           ((end_val != '0) && (cnt_inc == end_val)));
    end

    // Count register with preset priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_cnt)
            cnt <= cnt_wdata;
        else if (wrap)
            cnt <= '0;
        else if (tick)
            cnt <= cnt_inc;
    end

    // One-shot halt flag: set on a wrap, cleared by an enabling write or by disable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stopped <= 1'b0;
        else if ((wr_ctl && ctl_wr_en) || !en)
            stopped <= 1'b0;
        else if (wrap && mode == MODE_ONESHOT)
            stopped <= 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && !wrap) |=> cnt == $past(cnt) + CNT_ONE); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> cnt == $past(cnt)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !wr_cnt) |=> cnt == '0); // R3
    AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && en && !wr_ctl) |=> stopped); // R5
endmodule

// File: rtl/tmr_irq.sv
// Interrupt state: sticky pending flag set by wraps and cleared by write-one.
// A wrap in the same cycle as a clear keeps the flag set.
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic clr,
    input  logic irq_en,
    output logic pending,
    output logic irq
);
    // Pending flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (wrap)
            pending <= 1'b1;
        else if (clr)
            pending <= 1'b0;
    end

    // Level interrupt gated by the enable.
    always_comb begin
        irq = pending && irq_en;
    end

    AST_PEND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> pending); // R9
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wrap) |=> !pending); // R9
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr) |=> pending); // R8
endmodule

// File: rtl/interval_timer.sv
// Top of the prescaled interval timer. It wires the register file, prescaler,
// counter and interrupt logic together and forms the read data.
// Assumes the bus is synchronous to clk and addresses registers by word.
module interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 28,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] end_val;
    logic             ctl_en;
    run_mode_e        ctl_mode;
    logic [DIV_W-1:0] ctl_div;
    logic             irq_en;
    logic             wr_cnt;
    logic             wr_ctl;
    logic             wr_irq;
    logic             tick;
    logic             run;
    logic [CNT_W-1:0] cnt;
    logic             stopped;
    logic             wrap;
    logic             pending;

    tmr_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .end_val   (end_val),
        .ctl_en    (ctl_en),
        .ctl_mode  (ctl_mode),
        .ctl_div   (ctl_div),
        .irq_en    (irq_en),
        .wr_cnt    (wr_cnt),
        .wr_ctl    (wr_ctl),
        .wr_irq    (wr_irq)
    );

    // Counting is allowed while enabled and not halted.
    always_comb begin
        run = ctl_en && !stopped;
    end

    tmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (wr_ctl),
        .div     (ctl_div),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .en        (ctl_en),
        .mode      (ctl_mode),
        .wr_ctl    (wr_ctl),
        .ctl_wr_en (bus_wdata[CTL_EN_BIT]),
        .wr_cnt    (wr_cnt),
        .cnt_wdata (bus_wdata[CNT_W-1:0]),
        .end_val   (end_val),
        .cnt       (cnt),
        .stopped   (stopped),
        .wrap      (wrap)
    );

    tmr_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .clr     (wr_irq && bus_wdata[IRQ_PEND_BIT]),
        .irq_en  (irq_en),
        .pending (pending),
        .irq     (irq)
    );

    // Read mux with unused bits held at zero.
    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel_e'(bus_addr))
            REG_END: bus_rdata[CNT_W-1:0] = end_val;
            REG_CNT: bus_rdata[CNT_W-1:0] = cnt;
            REG_CTL: begin
                bus_rdata[CTL_EN_BIT]   = ctl_en;
                bus_rdata[CTL_MODE_BIT] = ctl_mode;
                bus_rdata[DIV_W-1:0]    = ctl_div;
            end
            REG_IRQ: begin
                bus_rdata[IRQ_EN_BIT]   = irq_en;
                bus_rdata[IRQ_PEND_BIT] = pending;
            end
            default: bus_rdata = '0;
        endcase
    end

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pending && irq_en)); // R8
endmodule

// File: tb/test_interval_timer.sv
// Self-checking bench: arithmetic sweep over divisors, end values and waits,
// plus directed corner cases. Inputs change at the falling edge.
module test_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    localparam logic [1:0] A_END = 2'd0, A_CNT = 2'd1, A_CTL = 2'd2, A_IRQ = 2'd3;
    localparam logic [31:0] EN = 32'h1000_0000, PER = 32'h0100_0000;
    localparam logic [31:0] PND = 32'h0001_0000, IEN = 32'h0010_0000;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic start(input logic [31:0] endv, input logic [31:0] ctl, input int n);
        wr(A_CTL, 32'd0);
        wr(A_IRQ, PND);
        wr(A_END, endv);
        wr(A_CNT, 32'd0);
        wr(A_CTL, ctl);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset reg", v, 32'd0);
        end
        check("R1 irq low", {31'd0, irq}, 32'd0);

        // R3 R6 R7: periodic sweep with arithmetic expectations
        for (int d = 0; d < 4; d++) begin
            for (int e = 1; e <= 4; e++) begin
                for (int n = 5; n <= 13; n += 8) begin
                    int de, t;
                    de = (d <= 1) ? 1 : d;
                    t = n / de;
                    start(32'(e), EN | PER | 32'(d), n);
                    rd(A_CNT, v);
                    check("R7 R6 count sweep", v, 32'(t % e));
                    rd(A_IRQ, v);
                    check("R3 pending sweep", v, (t >= e) ? PND : 32'd0);
                end
            end
        end

        // R5: one-shot halts at zero after a wrap, restarts on enabling write
        start(32'd5, EN | 32'd2, 20);
        rd(A_CNT, v);
        check("R5 halted count", v, 32'd0);
        rd(A_IRQ, v);
        check("R5 pending after wrap", v, PND);
        wr(A_CTL, EN | 32'd2);
        repeat (2) @(negedge clk);
        rd(A_CNT, v);
        check("R5 restart count", v, 32'd1);

        // R8 R9: enable without clearing, then clear
        wr(A_IRQ, IEN);
        rd(A_IRQ, v);
        check("R9 zero write keeps pending", v, PND | IEN);
        check("R8 irq high", {31'd0, irq}, 32'd1);
        wr(A_IRQ, PND | IEN);
        rd(A_IRQ, v);
        check("R9 clear pending", v, IEN);
        check("R8 irq low after clear", {31'd0, irq}, 32'd0);

        // R9: wrap in same cycle as clear keeps pending
        start(32'd4, EN | PER | 32'd1, 7);
        wr(A_IRQ, PND);
        rd(A_IRQ, v);
        check("R9 wrap beats clear", v, PND);
        wr(A_IRQ, PND);
        rd(A_IRQ, v);
        check("R9 clear off wrap", v, 32'd0);

        // R10: preset wins over a tick
        start(32'd0, EN | PER | 32'd1, 3);
        rd(A_CNT, v);
        check("R2 free count", v, 32'd3);
        wr(A_CNT, 32'd100);
        rd(A_CNT, v);
        check("R10 preset", v, 32'd100);
        @(negedge clk);
        rd(A_CNT, v);
        check("R10 step after preset", v, 32'd101);

        // R4: natural overflow
        wr(A_CTL, 32'd0);
        wr(A_IRQ, PND);
        wr(A_END, 32'd0);
        wr(A_CNT, 32'hFFFF_FFFE);
        wr(A_CTL, EN | PER | 32'd1);
        rd(A_CNT, v);
        check("R4 preset near top", v, 32'h0FFF_FFFE);
        @(negedge clk);
        rd(A_CNT, v);
        check("R4 at top", v, 32'h0FFF_FFFF);
        @(negedge clk);
        rd(A_CNT, v);
        check("R4 wrapped", v, 32'd0);
        rd(A_IRQ, v);
        check("R4 pending", v, PND);

        // R2: disable holds the count
        repeat (3) @(negedge clk);
        wr(A_CTL, 32'd0);
        rd(A_CNT, held);
        repeat (6) @(negedge clk);
        rd(A_CNT, v);
        check("R2 hold when disabled", v, held);

        // R11: read masks
        wr(A_IRQ, PND);
        wr(A_CTL, 32'hFFFF_FFFF);
        rd(A_CTL, v);
        check("R11 control mask", v, 32'h1100_FFFF);
        wr(A_CTL, 32'd0);
        wr(A_END, 32'hFFFF_FFFF);
        rd(A_END, v);
        check("R11 end mask", v, 32'h0FFF_FFFF);
        wr(A_IRQ, 32'hFFFF_FFFF);
        rd(A_IRQ, v);
        check("R11 irq mask", v, IEN);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule